// File: doc/BRIEF.md
# Status-Polled Flash Bank Sequencer

This block runs the erase and program procedures of a byte-wide parallel flash that reports progress through a status register. The flash is split into equal banks. Bank `n` begins at byte address `n * BANK_BYTES`, which is `n * 0x2000` with the default size. A single start request erases one whole bank or programs one whole bank. Program data comes from a byte source that the block indexes by offset.

For an erase, the block sends the erase command pair and then polls the status byte until the ready bit is set. For a program, it handles the bank one byte at a time. Each byte gets a setup command, a minimum settle gap, the data write, and then a status poll. Every operation ends with a clear-status command followed by a return to read-array mode. Unless the poll timed out, the block then reads back the whole bank and compares it with the expected contents, which are all 0xFF after an erase and the source bytes after a program.

The flash bus is a single-cycle write strobe and a read strobe. Read data is expected on `flRdata` in the cycle after `flRe`. The byte source is combinational: `srcData` must show the byte at offset `srcIdx` in the same cycle.

Top module: `flash_bank_seq`

## Requirements
- R1: An erase writes command 0x20 and then 0xD0, both to the bank base address `bankSel * BANK_BYTES`. No byte outside the selected bank is touched.
- R2: A completion poll writes 0x70 to the bank base and then reads one status byte. The poll repeats until bit 7 of that byte is 1.
- R3: If POLL_LIMIT polls in a row find bit 7 clear, the operation stops with `timedOut=1` and `failed=1`. No further byte is programmed and no readback is done.
- R4: Every operation, including one that timed out, ends with command 0x50 and then 0xFF written to the bank base. These are the last two bus writes of the operation.
- R5: After an erase, every byte of the bank is read back. The operation reports `failed=1` if any byte is not 0xFF.
- R6: Programming byte `i` writes 0x40 to `base+i` and then the data byte to the same address. The data write comes at least GAP_CYC clock cycles after the setup write, where GAP_CYC = CLK_HZ/1e6 * GAP_NS/1000, and is never less than 1.
- R7: After programming, every byte at `base+i` is read back and compared with source byte `i`. Any difference reports `failed=1`.
- R8: `errStatus` holds the last polled status byte ANDed with 0x38 (bits 5:3), so its other bits are always 0. It is cleared when an operation starts.
- R9: `startReq` is accepted only while `busy` is 0; a request during an operation is ignored. `done` is a one-cycle pulse in the last busy cycle, after which `busy` is 0. `flWe` and `flRe` are never high together, and neither is high while idle.
- R10: Bytes are programmed in ascending offset order starting at 0, and `srcIdx` equals the offset being written or verified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start an operation (taken only when idle) |
| opProgram | input | 1 | 1 = program the bank, 0 = erase it |
| bankSel | input | BANK_W | Bank index |
| srcIdx | output | OFS_W | Offset of the source byte wanted |
| srcData | input | 8 | Source byte at `srcIdx`, same cycle |
| flWe | output | 1 | Flash write strobe |
| flRe | output | 1 | Flash read strobe |
| flAddr | output | ADDR_W | Flash byte address |
| flWdata | output | 8 | Flash write data or command |
| flRdata | input | 8 | Flash read data, valid the cycle after `flRe` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| failed | output | 1 | Verify mismatch or timeout in the last operation |
| timedOut | output | 1 | Poll limit reached in the last operation |
| errStatus | output | 8 | Captured status error bits (mask 0x38) |

## Verification
The bound checker watches the command stream on every cycle. It checks that the erase confirm always follows its setup at the same address, that each data write keeps the settle gap after its setup, and that no poll run goes past the limit. It also checks that reset-to-read always follows clear-status, that the two strobes never overlap, that `errStatus` stays within its mask, and that the completion pulse and busy flag behave as R9 requires. Whether the bank really ends up erased or programmed, whether readback catches a bad byte, and how a hung device is handled can only be shown by the bench scenarios. These run against a behavioural flash model with injected faults (a stuck byte, an unerased target, a device that never becomes ready, and error bits in the status byte), mixed with randomized bank and data runs.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_STATUS_RD   = 8'h70;
  localparam logic [7:0] CMD_STATUS_CLR  = 8'h50;
  localparam logic [7:0] CMD_ARRAY_MODE  = 8'hFF;

  localparam int         STAT_READY_BIT = 7;
  localparam logic [7:0] STAT_ERR_MASK  = 8'h38;
  localparam logic [7:0] ERASED_BYTE    = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_ERS_SETUP, S_ERS_GO, S_PGM_SETUP, S_PGM_GAP, S_PGM_DATA,
    S_POLL_CMD, S_POLL_RD, S_POLL_EVAL, S_CLR, S_RST, S_VER_RD, S_VER_CMP,
    S_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       busWr;
    logic       busRd;
    logic       useOfs;
    logic       useSrc;
    logic [7:0] opcode;
    logic       latchReq;
    logic       clrOfs;
    logic       incOfs;
    logic       clrPoll;
    logic       incPoll;
    logic       loadGap;
    logic       decGap;
    logic       capStatus;
    logic       setFail;
    logic       setTimeout;
  } seqStrobe_t;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int BANK_W     = 1,
  parameter int POLL_LIMIT = 1000000,
  parameter int GAP_CYC    = 100,
  localparam int OFS_W     = $clog2(BANK_BYTES),
  localparam int ADDR_W    = BANK_W + OFS_W,
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1),
  localparam int GAP_W     = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        st,
  input  logic              opProgram,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [7:0]        srcData,
  input  logic [7:0]        flRdata,
  output logic [OFS_W-1:0]  srcIdx,
  output logic              flWe,
  output logic              flRe,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flWdata,
  output logic              isProgram,
  output logic              lastOfs,
  output logic              gapZero,
  output logic              pollExhausted,
  output logic              statusReady,
  output logic              verifyMatch,
  output logic              failed,
  output logic              timedOut,
  output logic [7:0]        errStatus
);

  localparam logic [OFS_W-1:0]  OFS_LAST  = OFS_W'(BANK_BYTES - 1);
  localparam logic [POLL_W-1:0] POLL_MAX  = POLL_W'(POLL_LIMIT);
  localparam logic [GAP_W-1:0]  GAP_LOAD  = GAP_W'(GAP_CYC - 1);

  logic [BANK_W-1:0] bankReg;
  logic [OFS_W-1:0]  ofs;
  logic [POLL_W-1:0] pollCnt;
  logic [GAP_W-1:0]  gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankReg   <= '0;
      isProgram <= 1'b0;
      ofs       <= '0;
      pollCnt   <= '0;
      gapCnt    <= '0;
      failed    <= 1'b0;
      timedOut  <= 1'b0;
      errStatus <= '0;
    end else begin
      if (st.latchReq) begin
        bankReg   <= bankSel;
        isProgram <= opProgram;
        failed    <= 1'b0;
        timedOut  <= 1'b0;
        errStatus <= '0;
      end
      if (st.clrOfs)       ofs <= '0;
      else if (st.incOfs)  ofs <= ofs + 1'b1;
      if (st.clrPoll)      pollCnt <= '0;
      else if (st.incPoll) pollCnt <= pollCnt + 1'b1;
      if (st.loadGap)      gapCnt <= GAP_LOAD;
      else if (st.decGap)  gapCnt <= gapCnt - 1'b1;
      if (st.capStatus)    errStatus <= flRdata & STAT_ERR_MASK;
      if (st.setFail)      failed <= 1'b1;
      if (st.setTimeout)   timedOut <= 1'b1;
    end
  end

  assign srcIdx        = ofs;
  assign flWe          = st.busWr;
  assign flRe          = st.busRd;
  assign flAddr        = {bankReg, (st.useOfs ? ofs : OFS_W'(0))};
  assign flWdata       = st.useSrc ? srcData : st.opcode;
  assign lastOfs       = (ofs == OFS_LAST);
  assign gapZero       = (gapCnt == '0);
  assign pollExhausted = (pollCnt == POLL_MAX);
  assign statusReady   = flRdata[STAT_READY_BIT];
  assign verifyMatch   = (flRdata == (isProgram ? srcData : ERASED_BYTE));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       opProgram,
  input  logic       isProgram,
  input  logic       lastOfs,
  input  logic       gapZero,
  input  logic       pollExhausted,
  input  logic       statusReady,
  input  logic       verifyMatch,
  input  logic       timedOut,
  output seqStrobe_t st,
  output logic       busy,
  output logic       done
);

  seqState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    st  = '0;
    nxt = state;
    unique case (state)
      S_IDLE: if (startReq) begin
        st.latchReq = 1'b1;
        st.clrOfs   = 1'b1;
        nxt = opProgram ? S_PGM_SETUP : S_ERS_SETUP;
      end
      S_ERS_SETUP: begin
        st.busWr = 1'b1; st.opcode = CMD_ERASE_SETUP;
        nxt = S_ERS_GO;
      end
      S_ERS_GO: begin
        st.busWr = 1'b1; st.opcode = CMD_ERASE_GO; st.clrPoll = 1'b1;
        nxt = S_POLL_CMD;
      end
      S_PGM_SETUP: begin
        st.busWr = 1'b1; st.useOfs = 1'b1; st.opcode = CMD_PROG_SETUP;
        st.loadGap = 1'b1;
        nxt = S_PGM_GAP;
      end
      S_PGM_GAP: begin
        if (gapZero) nxt = S_PGM_DATA;
        else         st.decGap = 1'b1;
      end
      S_PGM_DATA: begin
        st.busWr = 1'b1; st.useOfs = 1'b1; st.useSrc = 1'b1;
        st.clrPoll = 1'b1;
        nxt = S_POLL_CMD;
      end
      S_POLL_CMD: begin
        st.busWr = 1'b1; st.opcode = CMD_STATUS_RD; st.incPoll = 1'b1;
        nxt = S_POLL_RD;
      end
      S_POLL_RD: begin
        st.busRd = 1'b1;
        nxt = S_POLL_EVAL;
      end
      S_POLL_EVAL: begin
        st.capStatus = 1'b1;
        if (statusReady) begin
          if (isProgram && !lastOfs) begin
            st.incOfs = 1'b1;
            nxt = S_PGM_SETUP;
          end else begin
            nxt = S_CLR;
          end
        end else if (pollExhausted) begin
          st.setTimeout = 1'b1;
          st.setFail    = 1'b1;
          nxt = S_CLR;
        end else begin
          nxt = S_POLL_CMD;
        end
      end
      S_CLR: begin
        st.busWr = 1'b1; st.opcode = CMD_STATUS_CLR;
        nxt = S_RST;
      end
      S_RST: begin
        st.busWr = 1'b1; st.opcode = CMD_ARRAY_MODE; st.clrOfs = 1'b1;
        nxt = timedOut ? S_FINISH : S_VER_RD;
      end
      S_VER_RD: begin
        st.busRd = 1'b1; st.useOfs = 1'b1;
        nxt = S_VER_CMP;
      end
      S_VER_CMP: begin
        if (!verifyMatch) begin
          st.setFail = 1'b1;
          nxt = S_FINISH;
        end else if (lastOfs) begin
          nxt = S_FINISH;
        end else begin
          st.incOfs = 1'b1;
          nxt = S_VER_RD;
        end
      end
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);

endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
  import flash_seq_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int NUM_BANKS  = 2,
  parameter int CLK_HZ     = 100000000,
  parameter int GAP_NS     = 1000,
  parameter int POLL_LIMIT = 1000000,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OFS_W     = $clog2(BANK_BYTES),
  localparam int ADDR_W    = BANK_W + OFS_W,
  localparam int GAP_RAW   = (CLK_HZ / 1000000) * GAP_NS / 1000,
  localparam int GAP_CYC   = (GAP_RAW < 1) ? 1 : GAP_RAW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              opProgram,
  input  logic [BANK_W-1:0] bankSel,
  output logic [OFS_W-1:0]  srcIdx,
  input  logic [7:0]        srcData,
  output logic              flWe,
  output logic              flRe,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flWdata,
  input  logic [7:0]        flRdata,
  output logic              busy,
  output logic              done,
  output logic              failed,
  output logic              timedOut,
  output logic [7:0]        errStatus
);

  seqStrobe_t st;
  logic isProgram, lastOfs, gapZero, pollExhausted, statusReady, verifyMatch;

  flash_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opProgram(opProgram),
    .isProgram(isProgram), .lastOfs(lastOfs), .gapZero(gapZero),
    .pollExhausted(pollExhausted), .statusReady(statusReady),
    .verifyMatch(verifyMatch), .timedOut(timedOut), .st(st),
    .busy(busy), .done(done)
  );

  flash_seq_dp #(
    .BANK_BYTES(BANK_BYTES), .BANK_W(BANK_W),
    .POLL_LIMIT(POLL_LIMIT), .GAP_CYC(GAP_CYC)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .opProgram(opProgram),
    .bankSel(bankSel), .srcData(srcData), .flRdata(flRdata),
    .srcIdx(srcIdx), .flWe(flWe), .flRe(flRe), .flAddr(flAddr),
    .flWdata(flWdata), .isProgram(isProgram), .lastOfs(lastOfs),
    .gapZero(gapZero), .pollExhausted(pollExhausted),
    .statusReady(statusReady), .verifyMatch(verifyMatch),
    .failed(failed), .timedOut(timedOut), .errStatus(errStatus)
  );

endmodule

// File: rtl/flash_bank_seq_chk.sv
module flash_bank_seq_chk #(
  parameter int ADDR_W     = 14,
  parameter int POLL_LIMIT = 1000000,
  parameter int GAP_CYC    = 100,
  localparam int PW        = $clog2(POLL_LIMIT + 1),
  localparam int GW        = $clog2(GAP_CYC + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              failed,
  input logic              timedOut,
  input logic [7:0]        errStatus,
  input logic              flWe,
  input logic              flRe,
  input logic [ADDR_W-1:0] flAddr,
  input logic [7:0]        flWdata
);

  localparam logic [PW-1:0] POLL_MAX = PW'(POLL_LIMIT);
  localparam logic [GW-1:0] GAP_MIN  = GW'(GAP_CYC);
  localparam logic [GW-1:0] GAP_SAT  = GW'(GAP_CYC + 1);

  logic              lastWasSetup, lastWasClr;
  logic [7:0]        lastCmd;
  logic [ADDR_W-1:0] lastAddr;
  logic [PW-1:0]     pollRun;
  logic [GW-1:0]     sinceSetup;
  logic              isData;

  assign isData = lastWasSetup;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastWasSetup <= 1'b0;
      lastWasClr   <= 1'b0;
      lastCmd      <= '0;
      lastAddr     <= '0;
      pollRun      <= '0;
      sinceSetup   <= '0;
    end else begin
      if (sinceSetup < GAP_SAT) sinceSetup <= sinceSetup + 1'b1;
      if (flWe) begin
        lastAddr     <= flAddr;
        lastWasSetup <= !isData && (flWdata == 8'h40);
        lastWasClr   <= !isData && (flWdata == 8'h50);
        if (!isData) begin
          lastCmd <= flWdata;
          if (flWdata == 8'h70) pollRun <= pollRun + 1'b1;
          else                  pollRun <= '0;
          if (flWdata == 8'h40) sinceSetup <= GW'(1);
        end
      end
    end
  end

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(flWe && flRe));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!flWe && !flRe));
  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  p_confirm_order_r1: assert property (@(posedge clk) disable iff (!rstN)
    (flWe && !isData && flWdata == 8'hD0) |-> (lastCmd == 8'h20 && lastAddr == flAddr));
  p_poll_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (flWe && !isData && flWdata == 8'h70) |-> (pollRun < POLL_MAX));
  p_timeout_fails_r3: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> failed);
  p_reset_follows_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (flWe && lastWasClr) |-> (flWdata == 8'hFF));
  p_settle_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flWe && isData) |-> (sinceSetup >= GAP_MIN && flAddr == lastAddr));
  p_err_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errStatus & 8'hC7) == 8'h00);

endmodule

bind flash_bank_seq flash_bank_seq_chk #(
  .ADDR_W(ADDR_W), .POLL_LIMIT(POLL_LIMIT), .GAP_CYC(GAP_CYC)
) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .failed(failed),
  .timedOut(timedOut), .errStatus(errStatus), .flWe(flWe), .flRe(flRe),
  .flAddr(flAddr), .flWdata(flWdata)
);

// File: tb/flash_bank_seq_test.sv
`timescale 1ns/1ps
module flash_bank_seq_test;

  localparam int BB     = 32;
  localparam int NB     = 4;
  localparam int PL     = 20;
  localparam int GAPC   = 10;
  localparam int TOTAL  = BB * NB;
  localparam int PGMLAT = 2;
  localparam int ERSLAT = 5;
  localparam int LOGN   = 4096;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       opProgram = 1'b0;
  logic [1:0] bankSel = '0;
  logic [4:0] srcIdx;
  logic [7:0] srcData;
  logic       flWe, flRe;
  logic [6:0] flAddr;
  logic [7:0] flWdata;
  logic [7:0] flRdata = '0;
  logic       busy, done, failed, timedOut;
  logic [7:0] errStatus;

  always #5 clk = ~clk;

  flash_bank_seq #(
    .BANK_BYTES(BB), .NUM_BANKS(NB), .CLK_HZ(100000000),
    .GAP_NS(100), .POLL_LIMIT(PL)
  ) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opProgram(opProgram),
    .bankSel(bankSel), .srcIdx(srcIdx), .srcData(srcData), .flWe(flWe),
    .flRe(flRe), .flAddr(flAddr), .flWdata(flWdata), .flRdata(flRdata),
    .busy(busy), .done(done), .failed(failed), .timedOut(timedOut),
    .errStatus(errStatus)
  );

  logic [7:0] srcMem [BB];
  assign srcData = srcMem[srcIdx];

  // behavioural flash
  logic [7:0] mem [TOTAL];
  bit   statMode, pendSetup, pendErase, hang, stuckEn;
  int   busyCnt, stuckAddr;
  logic [7:0] errInj;
  // bus log
  int   wrA [LOGN];
  logic [7:0] wrD [LOGN];
  int   wrT [LOGN];
  int   nWr, nRd, doneCnt, cyc;
  int   nChecks = 0, nErr = 0;
  bit   finished = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (busyCnt > 0) busyCnt = busyCnt - 1;
    if (done) doneCnt = doneCnt + 1;
    if (flRe) begin
      nRd = nRd + 1;
      if (statMode)
        flRdata <= {(busyCnt == 0 && !hang), 7'b0} | (errInj & 8'h38);
      else
        flRdata <= mem[int'(flAddr)];
    end
    if (flWe) begin
      if (nWr < LOGN) begin
        wrA[nWr] = int'(flAddr); wrD[nWr] = flWdata; wrT[nWr] = cyc;
      end
      nWr = nWr + 1;
      if (pendSetup) begin
        mem[int'(flAddr)] = mem[int'(flAddr)] & flWdata;
        busyCnt = PGMLAT; pendSetup = 1'b0; statMode = 1'b1;
      end else begin
        case (flWdata)
          8'h40: pendSetup = 1'b1;
          8'h20: pendErase = 1'b1;
          8'hD0: if (pendErase) begin
            for (int i = 0; i < BB; i++) mem[(int'(flAddr) / BB) * BB + i] = 8'hFF;
            if (stuckEn) mem[stuckAddr] = 8'h00;
            busyCnt = ERSLAT; pendErase = 1'b0; statMode = 1'b1;
          end
          8'h70: statMode = 1'b1;
          8'hFF: statMode = 1'b0;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  task automatic runOp(bit prog, int bank, bit poke = 1'b0);
    int n;
    nWr = 0; nRd = 0; doneCnt = 0;
    @(negedge clk);
    startReq = 1'b1; opProgram = prog; bankSel = 2'(bank);
    @(negedge clk);
    startReq = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      if (poke && n == 7) begin startReq = 1'b1; bankSel = 2'(bank ^ 1); end
      else startReq = 1'b0;
      @(negedge clk); n++;
    end
    startReq = 1'b0;
    if (n >= 20000) chk("R9 done never seen", 0, 1);
    @(negedge clk);
  endtask

  function automatic int countCmd(logic [7:0] v);
    int c = 0; bit setup = 0;
    for (int k = 0; k < nWr && k < LOGN; k++) begin
      if (setup) setup = 0;
      else begin
        if (wrD[k] == v) c++;
        setup = (wrD[k] == 8'h40);
      end
    end
    return c;
  endfunction

  task automatic checkTail(string tag, int base);
    chk({tag, " R4 clear"}, {wrA[nWr-2], 24'(wrD[nWr-2])}, {base, 24'h50});
    chk({tag, " R4 reset"}, {wrA[nWr-1], 24'(wrD[nWr-1])}, {base, 24'hFF});
  endtask

  task automatic checkProgramLog(int base);
    int k = 0; bit ok = 1;
    for (int i = 0; i < BB; i++) begin
      while (k < nWr && !(wrD[k] == 8'h40 && wrA[k] == base + i)) k++;
      if (k + 1 >= nWr || wrA[k+1] != base + i || wrD[k+1] != srcMem[i]
          || wrT[k+1] - wrT[k] < GAPC) ok = 0;
      k += 2;
    end
    chk("R6 setup/data pairs with gap", 32'(ok), 1);
    chk("R10 ascending offsets", 32'(countCmd(8'h40)), BB);
  endtask

  function automatic bit bankIs(int bank, bit useSrc, logic [7:0] v);
    for (int i = 0; i < BB; i++)
      if (mem[bank*BB + i] !== (useSrc ? srcMem[i] : v)) return 0;
    return 1;
  endfunction

  initial begin
    #(200000 * 10);
    nErr++; nChecks++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [7:0] keep [BB];
    void'($urandom(32'd7331));
    cyc = 0; busyCnt = 0; errInj = 0; hang = 0; stuckEn = 0; stuckAddr = 0;
    statMode = 0; pendSetup = 0; pendErase = 0;
    for (int i = 0; i < TOTAL; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < BB; i++) srcMem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk("R9 reset busy", 32'(busy), 0);
    chk("R9 reset strobes", {30'b0, flWe, flRe}, 0);
    chk("R3 reset flags", {29'b0, done, failed, timedOut}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // erase bank 1
    for (int i = 0; i < BB; i++) keep[i] = mem[i];
    runOp(0, 1);
    chk("R1 erase setup", {wrA[0], 24'(wrD[0])}, {BB, 24'h20});
    chk("R1 erase confirm", {wrA[1], 24'(wrD[1])}, {BB, 24'hD0});
    chk("R2 poll cmd at base", {wrA[2], 24'(wrD[2])}, {BB, 24'h70});
    checkTail("erase", BB);
    chk("R5 erase ok", {30'b0, failed, timedOut}, 0);
    chk("R5 bank all FF", 32'(bankIs(1, 0, 8'hFF)), 1);
    begin
      bit same = 1;
      for (int i = 0; i < BB; i++) if (mem[i] !== keep[i]) same = 0;
      chk("R1 other bank untouched", 32'(same), 1);
    end
    chk("R2 polls until ready", 32'(countCmd(8'h70) >= 2), 1);
    chk("R9 one done pulse", doneCnt, 1);

    // program bank 1
    runOp(1, 1);
    checkProgramLog(BB);
    checkTail("program", BB);
    chk("R7 program ok", 32'(failed), 0);
    chk("R7 bank holds source", 32'(bankIs(1, 1, 0)), 1);

    // program over unerased bank: readback must mismatch
    for (int i = 0; i < BB; i++) begin mem[3*BB + i] = 8'h00; srcMem[i] = 8'hA5; end
    runOp(1, 3);
    chk("R7 mismatch reported", 32'(failed), 1);

    // stuck byte after erase
    stuckEn = 1; stuckAddr = 5;
    runOp(0, 0);
    chk("R5 stuck byte reported", 32'(failed), 1);
    stuckEn = 0;

    // status error bits captured, then cleared by next op
    errInj = 8'hDB;
    runOp(0, 2);
    chk("R8 error bits captured", 32'(errStatus), 32'h18);
    chk("R8 error bits no fail", 32'(failed), 0);
    errInj = 8'h00;
    runOp(0, 2);
    chk("R8 cleared on start", 32'(errStatus), 0);

    // start during busy ignored
    runOp(0, 2, 1'b1);
    begin
      bit inBank = 1;
      for (int k = 0; k < nWr; k++) if (wrA[k] / BB != 2) inBank = 0;
      chk("R9 start while busy ignored", {31'b0, inBank}, 1);
    end
    chk("R9 single done", doneCnt, 1);

    // hung device during erase
    hang = 1;
    runOp(0, 2);
    chk("R3 timeout flags", {30'b0, timedOut, failed}, 3);
    chk("R3 poll count", countCmd(8'h70), PL);
    chk("R3 no readback", nRd, PL);
    checkTail("erase timeout", 2*BB);
    // hung device during program
    runOp(1, 2);
    chk("R3 program stops early", countCmd(8'h40), 1);
    chk("R3 program timeout", 32'(timedOut), 1);
    checkTail("program timeout", 2*BB);
    hang = 0;

    // randomized erase+program rounds
    for (int it = 0; it < 4; it++) begin
      int b = int'($urandom % NB);
      for (int i = 0; i < BB; i++) srcMem[i] = 8'($urandom);
      runOp(0, b);
      chk("R5 random erase", {31'b0, bankIs(b, 0, 8'hFF)} | {31'b0, failed}, 1);
      runOp(1, b);
      chk("R7 random program", {30'b0, bankIs(b, 1, 0), failed}, 2);
      checkProgramLog(b * BB);
    end

    finishRun();
  end

endmodule